// File: doc/BRIEF.md
# Receive Pause Frame Detector and Transmit Hold-Off Timer

This block sits next to an Ethernet receive path and inspects the bytes of each incoming frame. It looks for flow-control frames that ask the far end to stop sending. When one of these frames ends with a good CRC, it reads the 16-bit quanta field. If receive flow control is enabled, it loads that value into a countdown timer. The timer drops by one on each slot tick, and one slot is 512 bit times. While the count is above zero, `pauseActive` is high, and the transmitter uses it to stop a new frame from starting.

For each recognised frame, the block also gives a one-cycle `rxCtrlPulse` that interrupt logic can use. It gives a one-cycle `dropFrame` so the buffer logic can discard the frame when pass-through of control frames is off. The CRC check is done upstream and reaches the block as the `frameGood` strobe, which is sampled on the last byte.

Top module: `pause_frame_det`

## Requirements
- R1: After reset, and while `rstN` is low, `pauseActive`, `rxCtrlPulse` and `dropFrame` are 0 and the timer holds zero.
- R2: A frame is recognised only when all of the following hold. Bytes 0..5 (byte 0 is the byte marked by `rxSof`) are 01,80,C2,00,00,01. Bytes 12..13 are 88,08. Bytes 14..15 are 00,01. Bytes 6..11 (the sender address) are not compared. A mismatch in any compared byte means the frame has no effect.
- R3: With `cfgRxFlow`=1, a recognised good frame loads bytes 16 (high) and 17 (low) as the pause count. `pauseActive` is high from the cycle after the end byte is accepted.
- R4: Each `slotTick` cycle lowers a nonzero count by one. With count N loaded, `pauseActive` stays high after N-1 ticks and is low in the cycle after the Nth tick.
- R5: A recognised good frame with count 0 and `cfgRxFlow`=1 leaves `pauseActive` low, or ends an active pause in the next cycle.
- R6: A recognised good frame that arrives during a pause replaces the remaining count with its own value.
- R7: With `cfgRxFlow`=0, recognised frames never raise `pauseActive`.
- R8: `rxCtrlPulse` is high for exactly one cycle, in the cycle after the end byte of a recognised good frame, whatever the values of `cfgRxFlow` and `cfgPassAll`.
- R9: `dropFrame` is high in the same single cycle as `rxCtrlPulse` when `cfgPassAll`=0, and stays low when `cfgPassAll`=1.
- R10: A frame whose end byte comes with `frameGood`=0, or whose total length (end byte included) is below 64 bytes, produces no pulse and no change to the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | `rxData` holds a byte this cycle |
| rxSof | input | 1 | Current byte is the first byte of a frame |
| rxEof | input | 1 | Current byte is the last byte of a frame |
| frameGood | input | 1 | CRC verdict for the frame, sampled with `rxEof` |
| cfgRxFlow | input | 1 | Honour received pause requests |
| cfgPassAll | input | 1 | Pass control frames on to the buffer (1) or drop them (0) |
| slotTick | input | 1 | One-cycle pulse per 512-bit-time slot |
| pauseActive | output | 1 | Transmit start must be held off |
| rxCtrlPulse | output | 1 | One-cycle marker of a recognised pause frame |
| dropFrame | output | 1 | One-cycle request to discard the current frame |

## Verification
A vector table sends 64-byte pause frames with counts 0, 1, 2 and 0xFFFF under all four flag combinations. This separates the load path from the pulse and drop outputs, and the full-range count shows that the counter does not wrap or truncate. Directed frames then corrupt a single header byte (destination, type and opcode), change only the sender address, clear the CRC verdict, or stop one byte short. These show that exactly the compared fields and the 64-byte boundary decide recognition. Reload and zero-count frames sent during a live pause, plus a reset during a pause, cover the timer's override paths.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;

  localparam int HDR_BYTES = 16;
  localparam int QUANTA_FIRST = 16;

  typedef struct packed {
    logic loadTimer;
    logic decTimer;
  } timerStrobe_t;

  // {compare-enable, expected byte} for header position idx
  function automatic logic [8:0] hdrExpect(input int unsigned idx);
    case (idx)
      0:  return {1'b1, 8'h01};
      1:  return {1'b1, 8'h80};
      2:  return {1'b1, 8'hC2};
      3:  return {1'b1, 8'h00};
      4:  return {1'b1, 8'h00};
      5:  return {1'b1, 8'h01};
      12: return {1'b1, 8'h88};
      13: return {1'b1, 8'h08};
      14: return {1'b1, 8'h00};
      15: return {1'b1, 8'h01};
      default: return {1'b0, 8'h00};
    endcase
  endfunction

endpackage

// File: rtl/pause_det_datapath.sv
module pause_det_datapath
  import pause_det_pkg::*;
#(
  parameter int QUANTA_BYTES = 2,
  parameter int MIN_LEN = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   rxData,
  input  logic         rxValid,
  input  logic         rxSof,
  input  timerStrobe_t strobes,
  output logic         frameHit,
  output logic         pauseActive
);

  localparam int QUANTA_W = 8 * QUANTA_BYTES;
  localparam int IDX_W = $clog2(MIN_LEN) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0]    byteIdx;
  logic [IDX_W-1:0]    curIdx;
  logic                hdrOk;
  logic                byteMatch;
  logic                lenOk;
  logic [8:0]          expByte;
  logic [QUANTA_W-1:0] quanta;
  logic [QUANTA_W-1:0] pauseCnt;

  assign curIdx    = rxSof ? '0 : byteIdx;
  assign expByte   = hdrExpect(int'(curIdx));
  assign byteMatch = ~expByte[8] | (rxData == expByte[7:0]);
  assign lenOk     = int'(curIdx) >= (MIN_LEN - 1);
  assign frameHit  = rxValid & ~rxSof & hdrOk & lenOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (rxValid) begin
      byteIdx <= (curIdx == IDX_MAX) ? curIdx : curIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrOk <= 1'b0;
    end else if (rxValid && int'(curIdx) < HDR_BYTES) begin
      hdrOk <= (rxSof | hdrOk) & byteMatch;
    end
  end

  generate
    if (QUANTA_BYTES == 1) begin : g_q1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) quanta <= '0;
        else if (rxValid && int'(curIdx) == QUANTA_FIRST) quanta <= rxData;
      end
    end else begin : g_qn
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          quanta <= '0;
        end else if (rxValid && int'(curIdx) >= QUANTA_FIRST &&
                     int'(curIdx) < QUANTA_FIRST + QUANTA_BYTES) begin
          quanta <= {quanta[QUANTA_W-9:0], rxData};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt <= '0;
    end else if (strobes.loadTimer) begin
      pauseCnt <= quanta;
    end else if (strobes.decTimer && pauseCnt != '0) begin
      pauseCnt <= pauseCnt - 1'b1;
    end
  end

  assign pauseActive = |pauseCnt;

endmodule

// File: rtl/pause_det_ctrl.sv
module pause_det_ctrl
  import pause_det_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxValid,
  input  logic         rxEof,
  input  logic         frameGood,
  input  logic         cfgRxFlow,
  input  logic         cfgPassAll,
  input  logic         slotTick,
  input  logic         frameHit,
  output timerStrobe_t strobes,
  output logic         rxCtrlPulse,
  output logic         dropFrame
);

  logic eofGood;

  assign eofGood           = rxValid & rxEof & frameGood & frameHit;
  assign strobes.loadTimer = eofGood & cfgRxFlow;
  assign strobes.decTimer  = slotTick & ~strobes.loadTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCtrlPulse <= 1'b0;
      dropFrame   <= 1'b0;
    end else begin
      rxCtrlPulse <= eofGood;
      dropFrame   <= eofGood & ~cfgPassAll;
    end
  end

endmodule

// File: rtl/pause_frame_det.sv
module pause_frame_det
  import pause_det_pkg::*;
#(
  parameter int QUANTA_BYTES = 2,
  parameter int MIN_LEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxEof,
  input  logic       frameGood,
  input  logic       cfgRxFlow,
  input  logic       cfgPassAll,
  input  logic       slotTick,
  output logic       pauseActive,
  output logic       rxCtrlPulse,
  output logic       dropFrame
);

  timerStrobe_t strobes;
  logic         frameHit;

  pause_det_datapath #(
    .QUANTA_BYTES(QUANTA_BYTES),
    .MIN_LEN(MIN_LEN)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .rxData(rxData),
    .rxValid(rxValid),
    .rxSof(rxSof),
    .strobes(strobes),
    .frameHit(frameHit),
    .pauseActive(pauseActive)
  );

  pause_det_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .rxValid(rxValid),
    .rxEof(rxEof),
    .frameGood(frameGood),
    .cfgRxFlow(cfgRxFlow),
    .cfgPassAll(cfgPassAll),
    .slotTick(slotTick),
    .frameHit(frameHit),
    .strobes(strobes),
    .rxCtrlPulse(rxCtrlPulse),
    .dropFrame(dropFrame)
  );

endmodule

// File: rtl/pause_frame_det_checker.sv
module pause_frame_det_checker (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic rxEof,
  input logic frameGood,
  input logic cfgRxFlow,
  input logic cfgPassAll,
  input logic slotTick,
  input logic pauseActive,
  input logic rxCtrlPulse,
  input logic dropFrame
);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxCtrlPulse |=> !rxCtrlPulse);

  assert_drop_with_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    dropFrame |-> rxCtrlPulse);

  assert_drop_needs_nopass_R9: assert property (@(posedge clk) disable iff (!rstN)
    dropFrame |-> !$past(cfgPassAll));

  assert_pulse_needs_good_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxCtrlPulse |-> $past(rxValid && rxEof && frameGood));

  assert_rise_needs_flow_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseActive) |-> (rxCtrlPulse && $past(cfgRxFlow)));

  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pauseActive) |-> ($past(slotTick) || rxCtrlPulse));

endmodule

bind pause_frame_det pause_frame_det_checker u_chk (
  .clk(clk),
  .rstN(rstN),
  .rxValid(rxValid),
  .rxEof(rxEof),
  .frameGood(frameGood),
  .cfgRxFlow(cfgRxFlow),
  .cfgPassAll(cfgPassAll),
  .slotTick(slotTick),
  .pauseActive(pauseActive),
  .rxCtrlPulse(rxCtrlPulse),
  .dropFrame(dropFrame)
);

// File: tb/pause_frame_det_bench.sv
module pause_frame_det_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       rxSof = 1'b0;
  logic       rxEof = 1'b0;
  logic       frameGood = 1'b0;
  logic       cfgRxFlow = 1'b0;
  logic       cfgPassAll = 1'b0;
  logic       slotTick = 1'b0;
  logic       pauseActive;
  logic       rxCtrlPulse;
  logic       dropFrame;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pause_frame_det u_pause_frame_det (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid),
    .rxSof(rxSof), .rxEof(rxEof), .frameGood(frameGood),
    .cfgRxFlow(cfgRxFlow), .cfgPassAll(cfgPassAll), .slotTick(slotTick),
    .pauseActive(pauseActive), .rxCtrlPulse(rxCtrlPulse), .dropFrame(dropFrame)
  );

  // {rxFlow, passAll, quanta[15:0], expDrop, expActive}
  localparam logic [19:0] VECS [8] = '{
    {1'b1, 1'b0, 16'h0001, 1'b1, 1'b1},
    {1'b1, 1'b1, 16'h0002, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0002, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0001, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] frameByte(input int i, input logic [15:0] q);
    case (i)
      0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
      3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
      12: return 8'h88; 13: return 8'h08;
      14: return 8'h00; 15: return 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return (i >= 6 && i < 12) ? 8'(i + 1) : 8'h00;
    endcase
  endfunction

  // called at a falling edge; returns at the falling edge after the end byte is taken
  task automatic sendFrame(input logic [15:0] q, input int len, input int badIdx, input logic good);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = frameByte(i, q);
      if (i == badIdx) b = b ^ 8'h01;
      rxData = b;
      rxValid = 1'b1;
      rxSof = (i == 0);
      rxEof = (i == len - 1);
      frameGood = (i == len - 1) && good;
      @(negedge clk);
    end
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; frameGood = 1'b0; rxData = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      slotTick = 1'b1;
      @(negedge clk);
      slotTick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..R10 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pauseActive", pauseActive, 0);
    check("R1 reset rxCtrlPulse", rxCtrlPulse, 0);
    check("R1 reset dropFrame", dropFrame, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: every flag pair, counts 0, 1, 2, 0xFFFF
    for (int v = 0; v < 8; v++) begin
      logic [15:0] q;
      logic expDrop, expAct;
      cfgRxFlow = VECS[v][19];
      cfgPassAll = VECS[v][18];
      q = VECS[v][17:2];
      expDrop = VECS[v][1];
      expAct = VECS[v][0];
      sendFrame(q, 64, -1, 1'b1);
      check("R8 pulse after good frame", rxCtrlPulse, 1);
      check("R9 drop vs passAll", dropFrame, expDrop);
      check("R3 R7 pause load", pauseActive, expAct);
      @(negedge clk);
      check("R8 pulse one cycle", rxCtrlPulse, 0);
      if (expAct) begin
        ticks(int'(q) - 1);
        check("R4 held before last tick", pauseActive, 1);
        ticks(1);
        check("R4 released at last tick", pauseActive, 0);
      end
    end

    cfgRxFlow = 1'b1;
    cfgPassAll = 1'b0;

    sendFrame(16'h0003, 64, -1, 1'b0);
    check("R10 bad CRC no pulse", rxCtrlPulse, 0);
    check("R10 bad CRC no pause", pauseActive, 0);

    sendFrame(16'h0003, 63, -1, 1'b1);
    check("R10 63-byte no pulse", rxCtrlPulse, 0);
    check("R10 63-byte no pause", pauseActive, 0);

    sendFrame(16'h0003, 64, 0, 1'b1);
    check("R2 dest byte0 mismatch", {rxCtrlPulse, pauseActive}, 0);
    sendFrame(16'h0003, 64, 5, 1'b1);
    check("R2 dest byte5 mismatch", {rxCtrlPulse, pauseActive}, 0);
    sendFrame(16'h0003, 64, 12, 1'b1);
    check("R2 type mismatch", {rxCtrlPulse, pauseActive}, 0);
    sendFrame(16'h0003, 64, 15, 1'b1);
    check("R2 opcode mismatch", {rxCtrlPulse, pauseActive}, 0);

    sendFrame(16'h0003, 64, 8, 1'b1);
    check("R2 sender addr ignored", {rxCtrlPulse, pauseActive}, 2'b11);
    @(negedge clk);
    sendFrame(16'h0000, 64, -1, 1'b1);
    check("R5 zero count ends pause", pauseActive, 0);
    check("R5 zero count pulse", rxCtrlPulse, 1);
    @(negedge clk);

    sendFrame(16'h0005, 64, -1, 1'b1);
    ticks(2);
    sendFrame(16'h0004, 64, -1, 1'b1);
    check("R6 reload still active", pauseActive, 1);
    ticks(3);
    check("R6 reload held for new count", pauseActive, 1);
    ticks(1);
    check("R6 reload expires at new count", pauseActive, 0);

    sendFrame(16'h0009, 64, -1, 1'b1);
    check("R3 pause before reset", pauseActive, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears pause", pauseActive, 0);
    check("R1 reset clears pulse", rxCtrlPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    ticks(2);
    check("R1 timer stays clear after reset", pauseActive, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule